// File: doc/BRIEF.md
# Registered Sixteen-Bit Arithmetic and Logic Unit

This block performs one arithmetic, bitwise or compare operation per clock on two 16-bit unsigned operands. A 4-bit opcode picks the operation from a sparse map. Addition uses a carry input. Subtraction reports a no-borrow flag. Five bitwise functions are provided. Four compares (equal, not equal, and two magnitude orderings) place their answer on a separate one-bit compare output. Codes outside the map are quiet: every output is driven to zero.

The operands, the opcode and the carry input are first latched into an input register. A combinational core reads that register and computes the answer. An output register then holds the result word, the carry-out, the zero flag and the compare bit. An operation driven before clock edge k is therefore visible after edge k+1. A new operation can be issued on every cycle. A synchronous active-high reset clears both register stages.

Top module: `alu16_top`

## Requirements
- R1: Opcode 4'b0000 gives result = (op_a + op_b + carry_in) mod 2^16, and carry_out = bit 16 of that 17-bit sum. For example, 0xFFFF + 0x0001 with carry_in 0 gives result 0x0000 and carry_out 1.
- R2: Opcode 4'b0001 gives result = (op_a - op_b) mod 2^16. carry_out is 1 exactly when op_a >= op_b, treated as unsigned.
- R3: Opcode 4'b0010 sets cmp_out to (op_a == op_b). Opcode 4'b0011 sets cmp_out to (op_a != op_b). For both codes, result and carry_out are 0.
- R4: The bitwise codes give: 4'b0100 XOR, 4'b0101 NOR, 4'b0110 OR, 4'b0111 AND, 4'b1010 NAND. For all of them, carry_out is 0.
- R5: Opcode 4'b1000 sets cmp_out when op_a < op_b. Opcode 4'b1001 sets cmp_out when op_b < op_a. Both compares are unsigned, and for both codes result and carry_out are 0.
- R6: Opcodes 4'b1011 through 4'b1111 drive result, carry_out, zero_flag and cmp_out all to 0.
- R7: For every opcode in R1 to R5, zero_flag is 1 exactly when the registered result is 0x0000. This means zero_flag is 1 for every compare opcode.
- R8: carry_in affects only opcode 4'b0000. It has no effect on any output for any other opcode.
- R9: Inputs present before rising edge k appear at the outputs after rising edge k+1. Operations issued on consecutive cycles come out on consecutive cycles.
- R10: While rst is high at a rising edge, both stages clear. After the next edge, all outputs read 0, including zero_flag.
- R11: cmp_out is 0 for every opcode that is not a compare (R3, R5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both register stages |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand, unsigned |
| op_b | input | 16 | Second operand, unsigned |
| opcode | input | 4 | Operation select |
| carry_in | input | 1 | Carry input, used by addition only |
| result | output | 16 | Registered result word |
| carry_out | output | 1 | Registered carry (add) or no-borrow (subtract) |
| zero_flag | output | 1 | Registered flag, high when the result is zero for a listed opcode |
| cmp_out | output | 1 | Registered compare answer |

## Verification
The assertions assume that the operands, opcode and carry input always carry known 0/1 values. They also assume that reset is held for at least one rising edge before any property is evaluated. The properties that look back one cycle rely on the input stage having been cleared during reset, so the first post-reset comparison sees a defined add of zeros. The stimulus respects these conditions: it holds reset from time zero, it changes every input only on falling edges, and it never leaves an input undriven.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int SUM_W  = DATA_W + 1;

    typedef logic [OP_W-1:0]   opcode_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam opcode_t OPC_ADD  = 4'b0000;
    localparam opcode_t OPC_SUB  = 4'b0001;
    localparam opcode_t OPC_EQ   = 4'b0010;
    localparam opcode_t OPC_NE   = 4'b0011;
    localparam opcode_t OPC_XOR  = 4'b0100;
    localparam opcode_t OPC_NOR  = 4'b0101;
    localparam opcode_t OPC_OR   = 4'b0110;
    localparam opcode_t OPC_AND  = 4'b0111;
    localparam opcode_t OPC_ALTB = 4'b1000;
    localparam opcode_t OPC_BLTA = 4'b1001;
    localparam opcode_t OPC_NAND = 4'b1010;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_CMP,
        CLS_NONE
    } op_class_e;

    typedef struct packed {
        word_t   a;
        word_t   b;
        opcode_t op;
        logic    cin;
    } alu_req_t;

    typedef struct packed {
        word_t res;
        logic  cy;
        logic  z;
        logic  cmp;
    } alu_rsp_t;

    localparam int REQ_W = $bits(alu_req_t);
    localparam int RSP_W = $bits(alu_rsp_t);

    function automatic op_class_e classify(opcode_t op);
        case (op)
            OPC_ADD, OPC_SUB:                   return CLS_ARITH;
            OPC_XOR, OPC_NOR, OPC_OR,
            OPC_AND, OPC_NAND:                  return CLS_LOGIC;
            OPC_EQ, OPC_NE, OPC_ALTB, OPC_BLTA: return CLS_CMP;
            default:                            return CLS_NONE;
        endcase
    endfunction

    function automatic logic is_zero(word_t v);
        return v == '0;
    endfunction

endpackage

// File: rtl/alu16_stage.sv
module alu16_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    assign b_eff    = sub ? ~b : b;
    assign chain[0] = sub ? 1'b1 : cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        assign p          = a[i] ^ b_eff[i];
        assign sum[i]     = p ^ chain[i];
        assign chain[i+1] = (a[i] & b_eff[i]) | (p & chain[i]);
    end

    assign cout = chain[W];
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  opcode_t      op,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            OPC_XOR:  y = a ^ b;
            OPC_NOR:  y = ~(a | b);
            OPC_OR:   y = a | b;
            OPC_AND:  y = a & b;
            OPC_NAND: y = ~(a & b);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/alu16_cmp.sv
module alu16_cmp
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  opcode_t      op,
    output logic         hit
);
    logic eq, a_lt_b, b_lt_a;

    assign eq     = (a == b);
    assign a_lt_b = (a < b);
    assign b_lt_a = (b < a);

    always_comb begin
        case (op)
            OPC_EQ:   hit = eq;
            OPC_NE:   hit = ~eq;
            OPC_ALTB: hit = a_lt_b;
            OPC_BLTA: hit = b_lt_a;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
(
    input  alu_req_t req,
    output alu_rsp_t rsp
);
    op_class_e   cls;
    word_t       sum, lgc;
    logic        cout, hit, add_cin;

    assign cls     = classify(req.op);
    assign add_cin = (req.op == OPC_ADD) ? req.cin : 1'b0;

    alu16_addsub #(.W(DATA_W)) u_addsub (
        .a   (req.a),
        .b   (req.b),
        .cin (add_cin),
        .sub (req.op == OPC_SUB),
        .sum (sum),
        .cout(cout)
    );

    alu16_logic #(.W(DATA_W)) u_logic (
        .a (req.a),
        .b (req.b),
        .op(req.op),
        .y (lgc)
    );

    alu16_cmp #(.W(DATA_W)) u_cmp (
        .a  (req.a),
        .b  (req.b),
        .op (req.op),
        .hit(hit)
    );

    always_comb begin
        rsp = '0;
        case (cls)
            CLS_ARITH: begin
                rsp.res = sum;
                rsp.cy  = cout;
            end
            CLS_LOGIC: rsp.res = lgc;
            CLS_CMP:   rsp.cmp = hit;
            default:   rsp = '0;
        endcase
        rsp.z = (cls != CLS_NONE) && is_zero(rsp.res);
    end
endmodule

// File: rtl/alu16_top.sv
module alu16_top
    import alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [OP_W-1:0]   opcode,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              zero_flag,
    output logic              cmp_out
);
    alu_req_t          req_d, req_q;
    alu_rsp_t          rsp_d, rsp_q;
    logic [REQ_W-1:0]  req_d_v, req_q_v;
    logic [RSP_W-1:0]  rsp_d_v, rsp_q_v;

    assign req_d.a   = op_a;
    assign req_d.b   = op_b;
    assign req_d.op  = opcode;
    assign req_d.cin = carry_in;
    assign req_d_v   = req_d;

    alu16_stage #(.W(REQ_W)) u_in_stage (
        .clk(clk), .rst(rst), .d(req_d_v), .q(req_q_v)
    );
    assign req_q = alu_req_t'(req_q_v);

    alu16_core u_core (
        .req(req_q),
        .rsp(rsp_d)
    );

    assign rsp_d_v = rsp_d;

    alu16_stage #(.W(RSP_W)) u_out_stage (
        .clk(clk), .rst(rst), .d(rsp_d_v), .q(rsp_q_v)
    );
    assign rsp_q = alu_rsp_t'(rsp_q_v);

    assign result    = rsp_q.res;
    assign carry_out = rsp_q.cy;
    assign zero_flag = rsp_q.z;
    assign cmp_out   = rsp_q.cmp;

    // R1: staged addition lands in the output register one edge later
    p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
        (req_q.op == OPC_ADD) |=> ({carry_out, result} ==
            $past({1'b0, req_q.a} + {1'b0, req_q.b} + {{DATA_W{1'b0}}, req_q.cin})));

    // R2: subtraction reports no-borrow
    p_sub_noborrow_r2: assert property (@(posedge clk) disable iff (rst)
        (req_q.op == OPC_SUB) |=> (carry_out == $past(req_q.a >= req_q.b)));

    // R3, R5: compares leave the result word and carry clear
    p_cmp_word_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (classify(req_q.op) == CLS_CMP) |=> (result == '0 && !carry_out));

    // R4: bitwise operations never raise carry or compare
    p_logic_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (classify(req_q.op) == CLS_LOGIC) |=> (!carry_out && !cmp_out));

    // R6: unused codes silence every output
    p_unused_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (classify(req_q.op) == CLS_NONE) |=>
            (result == '0 && !carry_out && !zero_flag && !cmp_out));

    // R7: zero flag never claims a nonzero word
    p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
        zero_flag |-> (result == '0));

    // R10: a reset edge clears every output
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (result == '0 && !carry_out && !zero_flag && !cmp_out));
endmodule

// File: tb/sim_alu16_top.sv
module sim_alu16_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0, op_b = '0;
    logic [3:0]  opcode = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        carry_out, zero_flag, cmp_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alu16_top u0 (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .carry_in(carry_in), .result(result), .carry_out(carry_out),
        .zero_flag(zero_flag), .cmp_out(cmp_out)
    );

    // expected {result, carry, zero, cmp} from the requirement text
    function automatic logic [18:0] model(logic [15:0] a, logic [15:0] b,
                                          logic [3:0] op, logic ci);
        logic [16:0] s;
        logic [15:0] r = '0;
        logic c = 0, k = 0, listed = 1;
        case (op)
            4'd0:  begin s = {1'b0, a} + {1'b0, b} + {16'd0, ci}; r = s[15:0]; c = s[16]; end
            4'd1:  begin r = a - b; c = (a >= b); end
            4'd2:  k = (a == b);
            4'd3:  k = (a != b);
            4'd4:  r = a ^ b;
            4'd5:  r = ~(a | b);
            4'd6:  r = a | b;
            4'd7:  r = a & b;
            4'd8:  k = (a < b);
            4'd9:  k = (b < a);
            4'd10: r = ~(a & b);
            default: listed = 0;
        endcase
        return {r, c, listed && (r == 16'd0), k};
    endfunction

    task automatic check(string req, logic [18:0] exp);
        logic [18:0] act = {result, carry_out, zero_flag, cmp_out};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual res=%h cy=%b z=%b cmp=%b expected res=%h cy=%b z=%b cmp=%b",
                     req, act[18:3], act[2], act[1], act[0], exp[18:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic drive(logic [15:0] a, logic [15:0] b, logic [3:0] op, logic ci);
        op_a = a; op_b = b; opcode = op; carry_in = ci;
    endtask

    // drive on a falling edge, wait through both stages, sample on a falling edge
    task automatic run(string req, logic [15:0] a, logic [15:0] b, logic [3:0] op, logic ci);
        @(negedge clk);
        drive(a, b, op, ci);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, model(a, b, op, ci));
    endtask

    task automatic t_reset;
        check("R10 reset state", 19'd0);
    endtask

    task automatic t_add;
        run("R1 add full carry chain", 16'hFFFF, 16'h0001, 4'd0, 1'b0);
        run("R1 add with carry in", 16'h1234, 16'h0FFF, 4'd0, 1'b1);
        run("R1 add no carry", 16'h0100, 16'h0023, 4'd0, 1'b0);
        run("R1 add carry in wraps", 16'hFFFF, 16'h0000, 4'd0, 1'b1);
    endtask

    task automatic t_sub;
        run("R2 sub a>b", 16'hAAAA, 16'h1555, 4'd1, 1'b0);
        run("R2 sub a<b borrow", 16'h1655, 16'h54AA, 4'd1, 1'b0);
        run("R2 sub a==b", 16'h7777, 16'h7777, 4'd1, 1'b0);
    endtask

    task automatic t_equality;
        run("R3 eq equal", 16'h5A5A, 16'h5A5A, 4'd2, 1'b0);
        run("R3 eq differ", 16'h5A5A, 16'h5A5B, 4'd2, 1'b0);
        run("R3 ne differ", 16'h5555, 16'hAAAA, 4'd3, 1'b0);
        run("R3 ne equal", 16'h0000, 16'h0000, 4'd3, 1'b0);
    endtask

    task automatic t_bitwise;
        run("R4 xor", 16'h5555, 16'hAAAA, 4'd4, 1'b0);
        run("R4 nor", 16'h0F0F, 16'h00FF, 4'd5, 1'b0);
        run("R4 or",  16'h0F00, 16'h00F0, 4'd6, 1'b0);
        run("R4 and", 16'hF0F0, 16'hFF00, 4'd7, 1'b0);
        run("R4 nand", 16'h6666, 16'h0000, 4'd10, 1'b0);
        run("R11 bitwise cmp low", 16'h1234, 16'h1234, 4'd7, 1'b0);
    endtask

    task automatic t_order;
        run("R5 a<b true",  16'h0001, 16'h8000, 4'd8, 1'b0);
        run("R5 a<b false", 16'h8000, 16'h0001, 4'd8, 1'b0);
        run("R5 a<b equal", 16'h4444, 16'h4444, 4'd8, 1'b0);
        run("R5 b<a true",  16'hFFFF, 16'h7FFF, 4'd9, 1'b0);
        run("R5 b<a false", 16'h7FFF, 16'hFFFF, 4'd9, 1'b0);
    endtask

    task automatic t_unused;
        for (int op = 11; op < 16; op++)
            run("R6 unused code", 16'hFFFF, 16'hFFFF, op[3:0], 1'b1);
    endtask

    task automatic t_zero;
        run("R7 xor self zero", 16'hBEEF, 16'hBEEF, 4'd4, 1'b0);
        run("R7 add wraps to zero", 16'h8000, 16'h8000, 4'd0, 1'b0);
        run("R7 sub nonzero", 16'h0002, 16'h0001, 4'd1, 1'b0);
    endtask

    task automatic t_carry_ignored;
        run("R8 sub ignores cin", 16'h0010, 16'h0003, 4'd1, 1'b1);
        run("R8 or ignores cin", 16'h0000, 16'h0000, 4'd6, 1'b1);
        run("R8 nand ignores cin", 16'hFFFF, 16'hFFFF, 4'd10, 1'b1);
        run("R8 eq ignores cin", 16'h0003, 16'h0004, 4'd2, 1'b1);
    endtask

    task automatic t_stream;
        @(negedge clk);
        drive(16'h0003, 16'h0004, 4'd0, 1'b0);
        @(negedge clk);
        drive(16'h00F0, 16'h0F00, 4'd6, 1'b0);
        @(negedge clk);
        drive(16'h0002, 16'h0009, 4'd8, 1'b0);
        check("R9 stream first", model(16'h0003, 16'h0004, 4'd0, 1'b0));
        @(negedge clk);
        check("R9 stream second", model(16'h00F0, 16'h0F00, 4'd6, 1'b0));
        @(negedge clk);
        check("R9 stream third", model(16'h0002, 16'h0009, 4'd8, 1'b0));
    endtask

    task automatic t_reset_mid;
        run("R10 before reset", 16'h1111, 16'h2222, 4'd6, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset mid stream", 19'd0);
        rst = 1'b0;
    endtask

    task automatic finish_up;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_add;
        t_sub;
        t_equality;
        t_bitwise;
        t_order;
        t_unused;
        t_zero;
        t_carry_ignored;
        t_stream;
        t_reset_mid;
        done = 1;
        finish_up;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            finish_up;
        end
    end
endmodule